// File: doc/BRIEF.md
# Free-Running Timer Status Flags with Read-Then-Clear Protection

This block is a 16-bit free-running up-counter with two compare registers (A and B), an overflow detector and one capture event input (channel D). Each of these four events sets a sticky flag in a single status register. A small byte-wide CPU register port gives access to the counter, both compare registers and the status register. The OR of all flags goes to the interrupt logic.

Software cannot set a flag, and it cannot clear one blindly. A flag is cleared only when software has first read the status register and seen that bit at 1, and then writes 0 to the same bit. Each flag has an internal arm bit that records the qualifying read. A flag that rises after the read is therefore not lost to a write meant for the earlier state. If a hardware event and a clearing write land in the same cycle, the event wins.

The register map is as follows. Counter high and low bytes are at addresses 0 and 1. Compare A high and low bytes are at 2 and 3. Compare B high and low bytes are at 4 and 5. The status register is at 6. Address 7 reads 0.

Top module: `evt_timer_status`

## Requirements
- R1: After reset all four flags and their arm bits are 0, the counter is 16'h0000 and `irq` is 0.
- R2: The counter steps by one at each clock edge where `cntEn` is 1. A CPU write to address 0 (high byte) or address 1 (low byte) loads that byte directly. A load takes priority over `cntEn` in the same cycle, and a load sets no flag.
- R3: Status bit 3 (compare A) becomes 1 at the clock edge where the counter advances to the value held in compare A (address 2 high byte, address 3 low byte).
- R4: Status bit 2 (compare B) becomes 1 at the clock edge where the counter advances to the value held in compare B (address 4 high byte, address 5 low byte).
- R5: Status bit 1 (overflow) becomes 1 at the clock edge where the counter advances from 16'hFFFF to 16'h0000. It does not become 1 when the counter only reaches 16'hFFFF.
- R6: Status bit 4 (capture D) becomes 1 at the first clock edge where `capIn` is sampled 1 after having been sampled 0.
- R7: A CPU write of 1 to a status bit never sets that bit. Status bits 7, 6, 5 and 0 always read 0.
- R8: A flag clears only on a write of 0 to its bit after a status read (address 6) that returned 1 in that bit. A write of 0 without such a read, including when the flag rose after the last read, leaves the flag at 1. Other bits of the same write are handled independently.
- R9: Any write to the status register drops all arm bits. After a write of 1 to an armed flag, a later write of 0 leaves the flag set until the bit is read again.
- R10: When a flag's set event and an armed clearing write fall in the same cycle, the flag stays 1 and its arm bit is dropped.
- R11: `irq` is 1 exactly when at least one of the four flags is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cntEn | input | 1 | Count enable pulse, one step per cycle high |
| capIn | input | 1 | Capture D event input, rising edge active |
| busAddr | input | 3 | Register address |
| busRd | input | 1 | Read strobe, data valid in the same cycle |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, zero when `busRd` is low |
| irq | output | 1 | OR of all status flags |

## Verification
Read data is combinational. The monitor compares `busRdata` on the falling edge inside the cycle where `busRd` is high. Counter, compare and capture flags take effect at the rising edge that ends the stimulus cycle. Each driver task ends one nanosecond after that edge, so the next read sees the new value. A clearing write acts at the rising edge that closes its strobe, so its result is read in a later cycle. The same-cycle collision of a capture edge and a clearing write is forced by driving both in one strobe cycle.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  localparam int NFLAG = 4;

  // register addresses
  localparam int ADR_CNT_HI = 0;
  localparam int ADR_CNT_LO = 1;
  localparam int ADR_A_HI   = 2;
  localparam int ADR_A_LO   = 3;
  localparam int ADR_B_HI   = 4;
  localparam int ADR_B_LO   = 5;
  localparam int ADR_STS    = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic ldCntHi;
    logic ldCntLo;
    logic ldAHi;
    logic ldALo;
    logic ldBHi;
    logic ldBLo;
  } dpStrobe_t;

  // hardware set events from datapath to control
  typedef struct packed {
    logic evOvf;
    logic evB;
    logic evA;
    logic evCap;
  } dpEvent_t;

  // flag index (0 cap, 1 A, 2 B, 3 overflow) to status bit position
  function automatic int flagBit(input int idx);
    return 4 - idx;
  endfunction

endpackage

// File: rtl/evt_timer_dp.sv
module evt_timer_dp
  import evt_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cntEn,
  input  logic              capIn,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  cntQ,
  output logic [CNT_W-1:0]  cmpAQ,
  output logic [CNT_W-1:0]  cmpBQ,
  output dpEvent_t          ev
);

  localparam int HI_W = CNT_W - DATA_W;

  logic [CNT_W-1:0] cntNext;
  logic             cntLoad;
  logic             advance;
  logic             capPrev;

  assign cntNext = cntQ + CNT_W'(1);
  assign cntLoad = strb.ldCntHi | strb.ldCntLo;
  assign advance = cntEn & ~cntLoad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntQ <= '0;
    end else if (cntLoad) begin
      if (strb.ldCntHi) cntQ[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
      if (strb.ldCntLo) cntQ[DATA_W-1:0]     <= wdata;
    end else if (cntEn) begin
      cntQ <= cntNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmpAQ <= '0;
      cmpBQ <= '0;
    end else begin
      if (strb.ldAHi) cmpAQ[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
      if (strb.ldALo) cmpAQ[DATA_W-1:0]     <= wdata;
      if (strb.ldBHi) cmpBQ[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
      if (strb.ldBLo) cmpBQ[DATA_W-1:0]     <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) capPrev <= 1'b0;
    else        capPrev <= capIn;
  end

  always_comb begin
    ev.evA   = advance & (cntNext == cmpAQ);
    ev.evB   = advance & (cntNext == cmpBQ);
    ev.evOvf = advance & (cntQ == {CNT_W{1'b1}});
    ev.evCap = capIn & ~capPrev;
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> cntQ == $past(cntQ) + CNT_W'(1));

  // R2
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.ldCntLo |=> cntQ[DATA_W-1:0] == $past(wdata));

  // R5
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && cntQ == {CNT_W{1'b1}}) |=> cntQ == '0);

  // R6
  cap_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev.evCap |=> !ev.evCap);

endmodule

// File: rtl/evt_timer_ctl.sv
module evt_timer_ctl
  import evt_timer_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  input  dpEvent_t          ev,
  input  logic [CNT_W-1:0]  cntQ,
  input  logic [CNT_W-1:0]  cmpAQ,
  input  logic [CNT_W-1:0]  cmpBQ,
  output dpStrobe_t         strb,
  output logic [DATA_W-1:0] dpWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);

  localparam int HI_W = CNT_W - DATA_W;

  logic              stsRd;
  logic              stsWr;
  logic [NFLAG-1:0]  evVec;
  logic [NFLAG-1:0]  flagQ;
  logic [NFLAG-1:0]  armQ;
  logic [DATA_W-1:0] stsByte;
  logic [DATA_W-1:0] rdMux;

  assign stsRd   = busRd & (busAddr == ADDR_W'(ADR_STS));
  assign stsWr   = busWr & (busAddr == ADDR_W'(ADR_STS));
  assign evVec   = {ev.evOvf, ev.evB, ev.evA, ev.evCap};
  assign dpWdata = busWdata;

  always_comb begin
    strb.ldCntHi = busWr & (busAddr == ADDR_W'(ADR_CNT_HI));
    strb.ldCntLo = busWr & (busAddr == ADDR_W'(ADR_CNT_LO));
    strb.ldAHi   = busWr & (busAddr == ADDR_W'(ADR_A_HI));
    strb.ldALo   = busWr & (busAddr == ADDR_W'(ADR_A_LO));
    strb.ldBHi   = busWr & (busAddr == ADDR_W'(ADR_B_HI));
    strb.ldBLo   = busWr & (busAddr == ADDR_W'(ADR_B_LO));
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    localparam int BP = flagBit(i);
    logic wrZero;
    assign wrZero = stsWr & ~busWdata[BP];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flagQ[i] <= 1'b0;
        armQ[i]  <= 1'b0;
      end else begin
        if (evVec[i])                flagQ[i] <= 1'b1;
        else if (wrZero && armQ[i])  flagQ[i] <= 1'b0;
        if (stsWr)                   armQ[i]  <= 1'b0;
        else if (stsRd && flagQ[i])  armQ[i]  <= 1'b1;
      end
    end

    // R7
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flagQ[i]) |-> $past(evVec[i]));

    // R8
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flagQ[i]) |-> $past(wrZero && armQ[i]));

    // R8
    arm_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armQ[i] |-> flagQ[i]);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evVec[i] && stsWr) |=> (flagQ[i] && !armQ[i]));
  end

  always_comb begin
    stsByte = '0;
    for (int k = 0; k < NFLAG; k++) stsByte[flagBit(k)] = flagQ[k];
  end

  always_comb begin
    rdMux = '0;
    case (busAddr)
      ADDR_W'(ADR_CNT_HI): rdMux[HI_W-1:0] = cntQ[CNT_W-1:DATA_W];
      ADDR_W'(ADR_CNT_LO): rdMux           = cntQ[DATA_W-1:0];
      ADDR_W'(ADR_A_HI):   rdMux[HI_W-1:0] = cmpAQ[CNT_W-1:DATA_W];
      ADDR_W'(ADR_A_LO):   rdMux           = cmpAQ[DATA_W-1:0];
      ADDR_W'(ADR_B_HI):   rdMux[HI_W-1:0] = cmpBQ[CNT_W-1:DATA_W];
      ADDR_W'(ADR_B_LO):   rdMux           = cmpBQ[DATA_W-1:0];
      ADDR_W'(ADR_STS):    rdMux           = stsByte;
      default:             rdMux           = '0;
    endcase
  end

  assign busRdata = busRd ? rdMux : '0;
  assign irq      = |flagQ;

endmodule

// File: rtl/evt_timer_status.sv
module evt_timer_status
  import evt_timer_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cntEn,
  input  logic              capIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);

  dpStrobe_t         strb;
  dpEvent_t          ev;
  logic [DATA_W-1:0] dpWdata;
  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  cmpAQ;
  logic [CNT_W-1:0]  cmpBQ;

  evt_timer_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busRd(busRd),
    .busWr(busWr), .busWdata(busWdata), .ev(ev), .cntQ(cntQ),
    .cmpAQ(cmpAQ), .cmpBQ(cmpBQ), .strb(strb), .dpWdata(dpWdata),
    .busRdata(busRdata), .irq(irq)
  );

  evt_timer_dp #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .cntEn(cntEn), .capIn(capIn), .strb(strb),
    .wdata(dpWdata), .cntQ(cntQ), .cmpAQ(cmpAQ), .cmpBQ(cmpBQ), .ev(ev)
  );

endmodule

// File: tb/evt_timer_status_bench.sv
module evt_timer_status_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cntEn = 1'b0;
  logic       capIn = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busRd = 1'b0;
  logic       busWr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t scb[$];

  always #4 clk = ~clk;

  evt_timer_status u_evt_timer_status (
    .clk(clk), .rst_n(rst_n), .cntEn(cntEn), .capIn(capIn),
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  // monitor: compare read data against scoreboard
  always @(negedge clk) begin
    if (busRd) begin
      if (scb.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read with no expected item, got %h", busRdata);
      end else begin
        item_t it;
        it = scb.pop_front();
        checks++;
        if (busRdata !== it.exp) begin
          errors++;
          $display("FAIL %s: got %h expected %h", it.tag, busRdata, it.exp);
        end
      end
    end
  end

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic rdChk(input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    @(posedge clk); #1;
    scb.push_back(it);
    busRd = 1'b1; busAddr = a;
    @(posedge clk); #1;
    busRd = 1'b0;
  endtask

  task automatic pulseEn(input int n);
    @(posedge clk); #1;
    cntEn = 1'b1;
    for (int k = 0; k < n; k++) @(posedge clk);
    #1 cntEn = 1'b0;
  endtask

  task automatic pulseCap();
    @(posedge clk); #1 capIn = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1 capIn = 1'b0;
  endtask

  task automatic chkIrq(input logic e, input string tag);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq got %b expected %b", tag, irq, e);
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rdChk(3'd6, 8'h00, "R1 status");
    rdChk(3'd0, 8'h00, "R1 cnt hi");
    rdChk(3'd1, 8'h00, "R1 cnt lo");
    chkIrq(1'b0, "R1 irq");

    wrReg(3'd2, 8'h00); wrReg(3'd3, 8'h05);
    wrReg(3'd4, 8'h00); wrReg(3'd5, 8'h03);
    rdChk(3'd3, 8'h05, "R3 cmpA lo");

    // R4 compare B at count 3
    pulseEn(3);
    chkIrq(1'b1, "R11 irq on");
    wrReg(3'd6, 8'h00);                        // no prior read
    rdChk(3'd6, 8'h04, "R8 write0 unarmed / R4");
    rdChk(3'd1, 8'h03, "R2 count");

    // R3 compare A at count 5
    pulseEn(2);
    rdChk(3'd6, 8'h0C, "R3 cmpA flag");
    wrReg(3'd6, 8'hFF);
    wrReg(3'd6, 8'h00);
    rdChk(3'd6, 8'h0C, "R9 arm dropped by write1");
    wrReg(3'd6, 8'h08);
    rdChk(3'd6, 8'h08, "R8 partial clear");
    wrReg(3'd6, 8'h00);
    rdChk(3'd6, 8'h00, "R8 clear");
    chkIrq(1'b0, "R11 irq off");

    // R7 cannot set
    wrReg(3'd6, 8'hFF);
    rdChk(3'd6, 8'h00, "R7 write1 no set");

    // R5 overflow
    wrReg(3'd0, 8'hFF); wrReg(3'd1, 8'hFE);
    rdChk(3'd0, 8'hFF, "R2 load hi");
    rdChk(3'd1, 8'hFE, "R2 load lo");
    rdChk(3'd6, 8'h00, "R2 load no flag");
    pulseEn(1);
    rdChk(3'd6, 8'h00, "R5 at FFFF");
    pulseEn(1);
    rdChk(3'd6, 8'h02, "R5 wrap");
    rdChk(3'd0, 8'h00, "R5 cnt hi");
    rdChk(3'd1, 8'h00, "R5 cnt lo");
    wrReg(3'd6, 8'h00);
    rdChk(3'd6, 8'h00, "R8 clear ovf");

    // R6 capture
    pulseCap();
    rdChk(3'd6, 8'h10, "R6 capture");
    wrReg(3'd6, 8'h00);
    rdChk(3'd6, 8'h00, "R8 clear cap");

    // R8 flag rises after read
    rdChk(3'd6, 8'h00, "R8 read zero");
    pulseCap();
    wrReg(3'd6, 8'h00);
    rdChk(3'd6, 8'h10, "R8 late set kept");

    // R10 set and armed clear in same cycle
    @(posedge clk); #1;
    busWr = 1'b1; busAddr = 3'd6; busWdata = 8'h00; capIn = 1'b1;
    @(posedge clk); #1;
    busWr = 1'b0;
    @(posedge clk); #1 capIn = 1'b0;
    wrReg(3'd6, 8'h00);
    rdChk(3'd6, 8'h10, "R10 set wins");
    wrReg(3'd6, 8'h00);
    rdChk(3'd6, 8'h00, "R10 later clear");

    // R2 load beats enable
    @(posedge clk); #1;
    busWr = 1'b1; busAddr = 3'd1; busWdata = 8'h40; cntEn = 1'b1;
    @(posedge clk); #1;
    busWr = 1'b0; cntEn = 1'b0;
    rdChk(3'd1, 8'h40, "R2 load priority");
    rdChk(3'd7, 8'h00, "R7 unused addr");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule